// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the timing strobes for an oversampling serial transmitter and receiver from the system clock. Software supplies a 16-bit divisor in unsigned fixed-point form, with a 12-bit whole part and a 4-bit part in sixteenths. The block then emits a one-cycle sample strobe at sixteen times the serial bit rate, so the bit rate is the clock frequency divided by sixteen times the divisor. For example, a 72 MHz clock with whole part 39 and fraction 1/16 gives a divisor of 39.0625 and a rate of about 115200 bit/s.

A whole-number divisor would force the rate to the nearest integer. This block instead keeps a 4-bit phase that gathers the fractional remainder from tick to tick. Each sample period is therefore either the whole part or one cycle longer, and the long-run average equals the programmed divisor exactly. A second strobe marks every sixteenth sample strobe and serves as the bit boundary. The divisor is captured when a load strobe is given. An enable input parks the generator with its counters cleared.

Top module: `frac_baud_gen`

## Requirements
- R1: On a clock edge with `divisorLoad` high, `divisorValue` is captured, whatever the state of `enable`. Bits 15:4 are the whole part (mantissa) and bits 3:0 are the fraction in sixteenths. The stored value is used from the following edge on.
- R2: Time zero is the last edge at which the counters were cleared: a load edge, or an edge with `enable` low. With D the full 16-bit divisor value read as an integer, the k-th `sampleTick` (k = 1, 2, ...) is high in the cycle after edge floor(k*D/16) past time zero, and at no other time.
- R3: Any sixteen consecutive sample periods starting at time zero add up to exactly D/16 * 16 = D clock cycles. Each individual period is either floor(D/16) or floor(D/16)+1 cycles.
- R4: While the stored mantissa is zero, no `sampleTick` and no `bitTick` is produced, whatever the fraction is.
- R5: `bitTick` is high together with the 16th, 32nd, 48th, ... `sampleTick` counted from time zero, and never without `sampleTick`.
- R6: An edge with `enable` low clears the phase and both counters and yields no tick in the following cycle. After `enable` returns high, timing restarts from the last low edge as described in R2.
- R7: A load edge clears the phase and the sample counter. No tick follows it, even when that edge would otherwise have produced a tick.
- R8: After a reset edge the stored divisor is zero, so no ticks occur until a divisor with a non-zero mantissa is loaded.
- R9: When the mantissa is 2 or more, `sampleTick` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the generator; low holds the counters at zero |
| divisorValue | input | 16 | Divisor: mantissa in bits 15:4, sixteenths in bits 3:0 |
| divisorLoad | input | 1 | Captures `divisorValue` and restarts the timing |
| sampleTick | output | 1 | One-cycle strobe at 16x the bit rate |
| bitTick | output | 1 | One-cycle strobe on every 16th sample strobe |

## Verification
A divisor load and a scheduled sample tick can fall on the same clock edge, and the load must win. The bench provokes this by loading a divisor with a non-zero fraction and counting cycles until the edge at which the next tick is due. It then strobes a new divisor onto exactly that edge. The result is judged correct only if no tick appears in the cycle after that edge, and if the subsequent tick and bit-tick timing follows the new divisor from a cleared phase and a cleared sample count.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  // Strobes from the control half to the counting datapath
  typedef struct packed {
    logic clear;  // zero phase, period and sample counters
    logic run;    // advance the counters this cycle
  } fbgStrobe_t;
endpackage

// File: rtl/fbg_ctrl.sv
module fbg_ctrl
  import fbg_pkg::*;
#(
  parameter int MANT_W = 12,
  parameter int FRAC_W = 4,
  localparam int DIV_W = MANT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divisorValue,
  input  logic              divisorLoad,
  output logic [MANT_W-1:0] mant,
  output logic [FRAC_W-1:0] frac,
  output fbgStrobe_t        strobe
);
  logic [DIV_W-1:0] divReg;
  logic validDiv;

  always_ff @(posedge clk) begin
    if (rst) begin
      divReg <= '0;
    end else if (divisorLoad) begin
      divReg <= divisorValue;
    end
  end

  assign mant     = divReg[DIV_W-1:FRAC_W];
  assign frac     = divReg[FRAC_W-1:0];
  assign validDiv = |mant;

  always_comb begin
    strobe.clear = divisorLoad | ~enable | ~validDiv;
    strobe.run   = ~strobe.clear;
  end
endmodule

// File: rtl/fbg_datapath.sv
module fbg_datapath
  import fbg_pkg::*;
#(
  parameter int MANT_W     = 12,
  parameter int FRAC_W     = 4,
  parameter int OVERSAMPLE = 16,
  localparam int SUB_W     = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MANT_W-1:0] mant,
  input  logic [FRAC_W-1:0] frac,
  input  fbgStrobe_t        strobe,
  output logic              sampleTick,
  output logic              bitTick
);
  logic [MANT_W-1:0] periodCnt;
  logic [FRAC_W-1:0] phaseAcc;
  logic [SUB_W-1:0]  subCnt;
  logic [SUB_W-1:0]  subNext;
  logic [FRAC_W:0]   phaseSum;
  logic [MANT_W:0]   lastCount;
  logic              atEnd;
  logic              lastSub;
  logic              tickQ;
  logic              bitQ;

  // A carry out of the phase sum stretches the current period by one cycle
  assign phaseSum  = {1'b0, phaseAcc} + {1'b0, frac};
  assign lastCount = {1'b0, mant} - {{MANT_W{1'b0}}, 1'b1}
                   + {{MANT_W{1'b0}}, phaseSum[FRAC_W]};
  assign atEnd     = ({1'b0, periodCnt} == lastCount);
  assign lastSub   = (subCnt == SUB_W'(OVERSAMPLE - 1));

  generate
    if ((1 << SUB_W) == OVERSAMPLE) begin : g_wrapPow2
      assign subNext = subCnt + {{(SUB_W-1){1'b0}}, 1'b1};
    end else begin : g_wrapCmp
      assign subNext = lastSub ? '0 : subCnt + {{(SUB_W-1){1'b0}}, 1'b1};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      periodCnt <= '0;
      phaseAcc  <= '0;
      subCnt    <= '0;
      tickQ     <= 1'b0;
      bitQ      <= 1'b0;
    end else if (strobe.run) begin
      if (atEnd) begin
        periodCnt <= '0;
        phaseAcc  <= phaseSum[FRAC_W-1:0];
        subCnt    <= subNext;
        tickQ     <= 1'b1;
        bitQ      <= lastSub;
      end else begin
        periodCnt <= periodCnt + {{(MANT_W-1){1'b0}}, 1'b1};
        tickQ     <= 1'b0;
        bitQ      <= 1'b0;
      end
    end else begin
      tickQ <= 1'b0;
      bitQ  <= 1'b0;
    end
  end

  assign sampleTick = tickQ;
  assign bitTick    = bitQ;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int MANT_W     = 12,
  parameter int FRAC_W     = 4,
  parameter int OVERSAMPLE = 16,
  localparam int DIV_W     = MANT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] divisorValue,
  input  logic             divisorLoad,
  output logic             sampleTick,
  output logic             bitTick
);
  logic [MANT_W-1:0] mantW;
  logic [FRAC_W-1:0] fracW;
  fbgStrobe_t        strobeW;

  fbg_ctrl #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) ctrl_i (
    .clk(clk), .rst(rst), .enable(enable),
    .divisorValue(divisorValue), .divisorLoad(divisorLoad),
    .mant(mantW), .frac(fracW), .strobe(strobeW)
  );

  fbg_datapath #(.MANT_W(MANT_W), .FRAC_W(FRAC_W), .OVERSAMPLE(OVERSAMPLE)) dp_i (
    .clk(clk), .rst(rst), .mant(mantW), .frac(fracW), .strobe(strobeW),
    .sampleTick(sampleTick), .bitTick(bitTick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int MANT_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              divisorLoad,
  input logic [MANT_W-1:0] divMant,
  input logic              sampleTick,
  input logic              bitTick
);
  AST_BIT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    bitTick |-> sampleTick);  // R5
  AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !sampleTick && !bitTick);  // R6
  AST_LOAD_SUPPRESSES_TICK: assert property (@(posedge clk) disable iff (rst)
    divisorLoad |=> !sampleTick);  // R7
  AST_ZERO_MANT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (divMant == '0) |=> !sampleTick && !bitTick);  // R4
  AST_SINGLE_CYCLE_TICK: assert property (@(posedge clk) disable iff (rst)
    sampleTick && (divMant > 1) |=> !sampleTick);  // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !sampleTick && !bitTick);  // R8
endmodule

bind frac_baud_gen fbg_checker #(.MANT_W(MANT_W)) chk_i (
  .clk(clk), .rst(rst), .enable(enable), .divisorLoad(divisorLoad),
  .divMant(mantW), .sampleTick(sampleTick), .bitTick(bitTick)
);

// File: tb/frac_baud_gen_tb_top.sv
`timescale 1ns/1ps
module frac_baud_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic divisorLoad = 1'b0;
  logic [15:0] divisorValue = '0;
  logic sampleTick, bitTick;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  frac_baud_gen dut_i (
    .clk(clk), .rst(rst), .enable(enable), .divisorValue(divisorValue),
    .divisorLoad(divisorLoad), .sampleTick(sampleTick), .bitTick(bitTick)
  );

  // Divisors walked by the main loop (bits 15:4 whole part, 3:0 sixteenths)
  localparam logic [15:0] VEC_DIV [8] = '{
    16'h0271, 16'h0270, 16'h0018, 16'h0010, 16'h002F, 16'h0038, 16'h003F, 16'h0011
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Starts and ends just after a falling edge; the load edge is time zero
  task automatic loadDiv(input logic [15:0] val);
    divisorValue = val;
    divisorLoad  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    divisorLoad  = 1'b0;
  endtask

  task automatic noTick(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (sampleTick || bitTick) seen++;
    end
    check(seen == 0, req, "cycles with a tick", seen, 0);
  endtask

  // Compare both strobes cycle by cycle against floor(k*D/16) after time zero
  task automatic observe(input int d, input int n, input string req);
    int k = 1;
    int nextT = d / 16;
    int badT = 0, badB = 0, firstAct = 0, firstExp = 0, t16 = -1;
    bit expT, expB;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk);
      @(negedge clk);
      expT = (i == nextT);
      expB = expT && (k % 16 == 0);
      if (sampleTick !== expT) begin
        if (badT == 0) begin firstAct = i; firstExp = nextT; end
        badT++;
      end
      if (bitTick !== expB) badB++;
      if (sampleTick && t16 < 0 && k == 16) t16 = i;
      if (expT) begin
        k++;
        nextT = (k * d) / 16;
      end
    end
    check(badT == 0, req, "sample tick timing (first bad cycle vs next due)",
          firstAct, firstExp);
    check(badB == 0, "R5", "bit tick mismatching cycles", badB, 0);
    if (n >= d) check(t16 == d, "R3", "cycle of 16th tick", t16, d);
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check(!sampleTick && !bitTick, "R8", "ticks during reset",
          int'(sampleTick) + int'(bitTick), 0);
    rst = 1'b0;
    enable = 1'b1;
    noTick(20, "R8");

    // R2: table of divisors walked in one loop
    foreach (VEC_DIV[j]) begin
      loadDiv(VEC_DIV[j]);
      observe(int'(VEC_DIV[j]), (int'(VEC_DIV[j]) * 20) / 16 + 4, "R2");
    end

    // R4: zero mantissa with and without a fraction
    loadDiv(16'h000F);
    noTick(100, "R4");
    loadDiv(16'h0000);
    noTick(40, "R4");

    // R6: enable low clears, restart from the last low edge
    loadDiv(16'h0030);
    observe(16'h0030, 10, "R6");
    enable = 1'b0;
    noTick(8, "R6");
    enable = 1'b1;
    observe(16'h0030, 60, "R6");

    // R1: load captured while disabled, used once enabled
    enable = 1'b0;
    loadDiv(16'h0050);
    noTick(5, "R1");
    enable = 1'b1;
    observe(16'h0050, 110, "R1");

    // R7: load lands on the edge where a tick is due (4.5625: ticks at 4, 9)
    loadDiv(16'h0049);
    observe(16'h0049, 8, "R7");
    divisorValue = 16'h0048;
    divisorLoad  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    divisorLoad  = 1'b0;
    check(!sampleTick, "R7", "tick after colliding load", int'(sampleTick), 0);
    observe(16'h0048, 90, "R7");

    // R8: reset mid-run clears the stored divisor
    loadDiv(16'h0020);
    observe(16'h0020, 9, "R2");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    noTick(40, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule